// File: doc/BRIEF.md
# Two-Wire Register and Page-Memory Access Port

This block is the control-bus slave of a text-display decoder. A host on a two-wire serial bus reaches eleven write-only control registers through it. A twelfth sub-address is a window into a display memory of four chapters, each holding 25 rows of 40 character bytes. The bus lines are oversampled by the system clock. The slave pulls the data line low only through an output enable, and the bus wiring supplies the pull-up.

A write transfer carries the slave address with a low direction bit, then one sub-address byte, then any number of data bytes. A read transfer returns bytes starting at the sub-address last loaded. The sub-address steps forward after every data byte in both directions. The window sub-address reaches the memory cell named by the chapter, row and column registers. A mode bit in register 0 decides whether a read at the window returns that memory byte or a status byte built from two sync-monitor inputs.

After reset, the memory is filled by a sweep that writes one byte per clock. The same sweep can be started again by a command bit. While it runs, a busy flag is raised.

Top module: `ttx_i2c_regif`

## Requirements
- R1: The slave answers only the 7-bit address 0010001 followed by the direction bit, pulling SDA low in the ninth clock. For any other address SDA stays released and no register or memory state changes.
- R2: In a write transfer the first byte after the address loads the sub-address. Each later data byte goes to the addressed location, after which the sub-address advances by one, wrapping from 0Bh (or from any value above it) to 00h.
- R3: Register n (00h–0Ah) appears on `ctrl_o[8n+7:8n]`. After reset all of them hold 00h except registers 05h and 06h, which hold 03h.
- R4: Reads at sub-addresses 00h–0Ah return 00h, and each read byte also advances the sub-address.
- R5: With register 0 bit 0 clear, a read at 0Bh returns the memory byte at chapter = register 08h bits 1:0, row = register 09h bits 4:0 and column = register 0Ah bits 5:0. A write at 0Bh always stores into that memory byte, whatever the state of register 0 bit 0.
- R6: With register 0 bit 0 set, a read at 0Bh returns the status byte. Bit 0 is the sync-good input. Bit 7 is the 60 Hz input when sync is good and 0 otherwise. Bits 6:1 are 0.
- R7: After reset every memory byte is 20h, except chapter 0 / row 0 / column 7, which is 07h. The fill writes one byte per clock, and `clr_busy_o` is high for the whole sweep.
- R8: Writing register 08h with bit 3 set restarts the same fill sweep. Bit 3 is not kept (it reads 0 on `ctrl_o`), and memory writes that arrive while the sweep runs are dropped.
- R9: A row value of 25 or more, or a column value of 40 or more, makes the window inert: writes are ignored and reads return 00h.
- R10: In a read, data leaves MSB first. A master acknowledge fetches the next byte, and a master not-acknowledge ends the transfer with SDA released. A STOP always releases SDA, and a repeated START returns to the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sync_good_i | input | 1 | Sync quality good |
| rate60_i | input | 1 | Field rate detected as 60 Hz |
| ctrl_o | output | 88 | Registers 00h–0Ah, register n in bits 8n+7:8n |
| clr_busy_o | output | 1 | Memory fill sweep in progress |

## Verification
The hardest case to reach from the ports is a memory write that arrives while a fill sweep runs. The bench reaches it with a single burst at sub-address 08h that sets the clear bit and then rolls on through the row, column and window sub-addresses. The window write therefore lands a few hundred cycles into a sweep that lasts thousands. Reading that cell back after the sweep gives 20h, which shows the write was dropped. The other subtle cases are the wrap from 0Bh to 00h and a read that crosses from a write-only register into the window; long bursts drive both.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
   localparam int         NUM_WREG   = 11;
   localparam logic [7:0] LAST_SUB   = 8'h0B;
   localparam int         REG_MODE   = 0;
   localparam int         REG_CHAP   = 8;
   localparam int         REG_ROW    = 9;
   localparam int         REG_COL    = 10;
   localparam logic [7:0] FILL_BYTE  = 8'h20;
   localparam logic [7:0] SEED_BYTE  = 8'h07;
   localparam logic [7:0] CLR_MASK   = 8'h08;
   localparam int         SEED_COL   = 7;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_AHOLD, ST_WR, ST_WACK, ST_WHOLD, ST_RD
   } link_state_t;

   function automatic logic [7:0] reg_reset(input int idx);
      return (idx == 5 || idx == 6) ? 8'h03 : 8'h00;
   endfunction
endpackage

// File: rtl/ttx_page_ram.sv
module ttx_page_ram #(
   parameter int DEPTH = 4000,
   parameter int AW    = 12
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/ttx_i2c_bitlink.sv
module ttx_i2c_bitlink
   import ttx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [7:0] rd_byte_i,
   output logic       wr_stb_o,
   output logic [7:0] wr_data_o,
   output logic       rd_stb_o,
   output logic       sel_w_o
);
   logic [1:0]  scl_sy, sda_sy;
   logic        scl_q, sda_q;
   logic        scl_s, sda_s;
   logic        rise, fall, start, stop;
   link_state_t state;
   logic [3:0]  bitcnt;
   logic [6:0]  shreg;
   logic        hit, rnw, mack, in_rack;
   logic [7:0]  nbyte;
   logic        do_load;

   assign scl_s = scl_sy[1];
   assign sda_s = sda_sy[1];
   assign rise  = scl_s & ~scl_q;
   assign fall  = ~scl_s & scl_q;
   assign start = scl_s & scl_q & sda_q & ~sda_s;
   assign stop  = scl_s & scl_q & ~sda_q & sda_s;
   assign nbyte = {shreg, sda_s};
   assign do_load = fall && ((state == ST_AHOLD && rnw) || (in_rack && mack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sy <= 2'b11;
         sda_sy <= 2'b11;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sy <= {scl_sy[0], scl_i};
         sda_sy <= {sda_sy[0], sda_i};
         scl_q  <= scl_s;
         sda_q  <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         hit       <= 1'b0;
         rnw       <= 1'b0;
         mack      <= 1'b0;
         in_rack   <= 1'b0;
         sda_oe_o  <= 1'b0;
         wr_stb_o  <= 1'b0;
         wr_data_o <= '0;
         rd_stb_o  <= 1'b0;
         sel_w_o   <= 1'b0;
      end else begin
         wr_stb_o <= 1'b0;
         rd_stb_o <= 1'b0;
         sel_w_o  <= 1'b0;
         if (start) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            in_rack  <= 1'b0;
            sda_oe_o <= 1'b0;
         end else if (stop) begin
            state    <= ST_IDLE;
            in_rack  <= 1'b0;
            sda_oe_o <= 1'b0;
         end else if (do_load) begin
            state    <= ST_RD;
            in_rack  <= 1'b0;
            shreg    <= rd_byte_i[6:0];
            sda_oe_o <= ~rd_byte_i[7];
            bitcnt   <= '0;
            rd_stb_o <= 1'b1;
         end else begin
            unique case (state)
               ST_ADDR: if (rise) begin
                  shreg  <= nbyte[6:0];
                  bitcnt <= bitcnt + 4'd1;
                  if (bitcnt == 4'd7) begin
                     hit   <= (nbyte[7:1] == DEV_ADDR);
                     rnw   <= nbyte[0];
                     state <= ST_AACK;
                  end
               end
               ST_AACK: if (fall) begin
                  if (hit) begin
                     sda_oe_o <= 1'b1;
                     state    <= ST_AHOLD;
                     sel_w_o  <= ~rnw;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_AHOLD: if (fall) begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_WR;
                  bitcnt   <= '0;
               end
               ST_WR: if (rise) begin
                  shreg  <= nbyte[6:0];
                  bitcnt <= bitcnt + 4'd1;
                  if (bitcnt == 4'd7) begin
                     wr_stb_o  <= 1'b1;
                     wr_data_o <= nbyte;
                     state     <= ST_WACK;
                  end
               end
               ST_WACK: if (fall) begin
                  sda_oe_o <= 1'b1;
                  state    <= ST_WHOLD;
               end
               ST_WHOLD: if (fall) begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_WR;
                  bitcnt   <= '0;
               end
               ST_RD: begin
                  if (in_rack) begin
                     if (rise) mack <= ~sda_s;
                     if (fall) begin
                        in_rack <= 1'b0;
                        state   <= ST_IDLE;
                     end
                  end else if (rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_oe_o <= 1'b0;
                        in_rack  <= 1'b1;
                     end else begin
                        sda_oe_o <= ~shreg[6];
                        shreg    <= {shreg[5:0], 1'b0};
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !sda_oe_o);
   p_nack_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_AACK && !hit) |=> !sda_oe_o);
   p_master_ack_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rack && !fall) |-> !sda_oe_o);
endmodule

// File: rtl/ttx_reg_window.sv
module ttx_reg_window
   import ttx_pkg::*;
#(
   parameter int CHAPTERS       = 4,
   parameter int ROWS           = 25,
   parameter int COLS           = 40,
   parameter bit CLEAR_ON_RESET = 1'b1,
   parameter int DEPTH          = CHAPTERS * ROWS * COLS,
   parameter int AW             = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_stb_i,
   input  logic [7:0]            wr_data_i,
   input  logic                  rd_stb_i,
   input  logic                  sel_w_i,
   input  logic                  sync_good_i,
   input  logic                  rate60_i,
   output logic [7:0]            rd_byte_o,
   output logic [8*NUM_WREG-1:0] ctrl_o,
   output logic                  busy_o,
   output logic                  ram_we_o,
   output logic [AW-1:0]         ram_waddr_o,
   output logic [7:0]            ram_wdata_o,
   output logic [AW-1:0]         ram_raddr_o,
   input  logic [7:0]            ram_rdata_i
);
   localparam int            PAGE     = ROWS * COLS;
   localparam logic [AW-1:0] SEED_IDX = AW'(SEED_COL);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [7:0]    regs [NUM_WREG];
   logic [7:0]    sub;
   logic          expect_sub;
   logic [AW-1:0] cnt;
   logic          in_range, host_we, clr_start, data_wr;
   logic [1:0]    chap;
   logic [4:0]    row;
   logic [5:0]    col;
   logic [AW-1:0] ptr;
   logic [7:0]    status;
   logic [7:0]    next_sub;

   assign chap     = regs[REG_CHAP][1:0];
   assign row      = regs[REG_ROW][4:0];
   assign col      = regs[REG_COL][5:0];
   assign in_range = (32'(chap) < CHAPTERS) && (32'(row) < ROWS) && (32'(col) < COLS);
   assign ptr      = AW'(32'(chap) * PAGE + 32'(row) * COLS + 32'(col));
   assign data_wr  = wr_stb_i && !expect_sub;
   assign clr_start = data_wr && sub == 8'(REG_CHAP) && (wr_data_i & CLR_MASK) != 8'h00;
   assign host_we  = data_wr && sub == LAST_SUB && in_range && !busy_o;
   assign next_sub = (sub >= LAST_SUB) ? 8'h00 : sub + 8'h01;
   assign status   = {rate60_i & sync_good_i, 6'b0, sync_good_i};

   genvar g;
   for (g = 0; g < NUM_WREG; g++) begin : g_ctrl
      assign ctrl_o[8*g +: 8] = regs[g];
   end

   always_comb begin
      rd_byte_o = 8'h00;
      if (sub == LAST_SUB)
         rd_byte_o = regs[REG_MODE][0] ? status : (in_range ? ram_rdata_i : 8'h00);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WREG; i++) regs[i] <= reg_reset(i);
         sub        <= 8'h00;
         expect_sub <= 1'b0;
      end else begin
         if (sel_w_i) expect_sub <= 1'b1;
         if (wr_stb_i) begin
            if (expect_sub) begin
               sub        <= wr_data_i;
               expect_sub <= 1'b0;
            end else begin
               if (sub < LAST_SUB)
                  regs[sub[3:0]] <= (sub == 8'(REG_CHAP)) ? (wr_data_i & ~CLR_MASK) : wr_data_i;
               sub <= next_sub;
            end
         end
         if (rd_stb_i) sub <= next_sub;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= CLEAR_ON_RESET;
         cnt    <= '0;
      end else if (clr_start) begin
         busy_o <= 1'b1;
         cnt    <= '0;
      end else if (busy_o) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST_IDX) busy_o <= 1'b0;
      end
   end

   assign ram_we_o    = busy_o | host_we;
   assign ram_waddr_o = busy_o ? cnt : ptr;
   assign ram_wdata_o = busy_o ? ((cnt == SEED_IDX) ? SEED_BYTE : FILL_BYTE) : wr_data_i;
   assign ram_raddr_o = ptr;

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && sub == LAST_SUB) |=> sub == 8'h00);
   p_sweep_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_start |=> (busy_o && cnt == '0));
endmodule

// File: rtl/ttx_i2c_regif.sv
module ttx_i2c_regif
   import ttx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR       = 7'h11,
   parameter int         CHAPTERS       = 4,
   parameter int         ROWS           = 25,
   parameter int         COLS           = 40,
   parameter bit         CLEAR_ON_RESET = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic                  sync_good_i,
   input  logic                  rate60_i,
   output logic [8*NUM_WREG-1:0] ctrl_o,
   output logic                  clr_busy_o
);
   localparam int DEPTH = CHAPTERS * ROWS * COLS;
   localparam int AW    = $clog2(DEPTH);

   if (CHAPTERS < 1 || CHAPTERS > 4) begin : g_bad_chap
      $error("CHAPTERS must fit the 2-bit chapter field");
   end
   if (ROWS < 1 || ROWS > 32) begin : g_bad_rows
      $error("ROWS must fit the 5-bit row field");
   end
   if (COLS <= SEED_COL || COLS > 64) begin : g_bad_cols
      $error("COLS must hold the seed column and fit the 6-bit column field");
   end

   logic          wr_stb, rd_stb, sel_w;
   logic [7:0]    wr_data, rd_byte, ram_wd, ram_rd;
   logic          ram_we;
   logic [AW-1:0] ram_wa, ram_ra;

   ttx_i2c_bitlink #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_oe_o  (sda_oe_o),
      .rd_byte_i (rd_byte),
      .wr_stb_o  (wr_stb),
      .wr_data_o (wr_data),
      .rd_stb_o  (rd_stb),
      .sel_w_o   (sel_w)
   );

   ttx_reg_window #(
      .CHAPTERS(CHAPTERS), .ROWS(ROWS), .COLS(COLS),
      .CLEAR_ON_RESET(CLEAR_ON_RESET), .DEPTH(DEPTH), .AW(AW)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb_i    (wr_stb),
      .wr_data_i   (wr_data),
      .rd_stb_i    (rd_stb),
      .sel_w_i     (sel_w),
      .sync_good_i (sync_good_i),
      .rate60_i    (rate60_i),
      .rd_byte_o   (rd_byte),
      .ctrl_o      (ctrl_o),
      .busy_o      (clr_busy_o),
      .ram_we_o    (ram_we),
      .ram_waddr_o (ram_wa),
      .ram_wdata_o (ram_wd),
      .ram_raddr_o (ram_ra),
      .ram_rdata_i (ram_rd)
   );

   ttx_page_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_wa),
      .wdata (ram_wd),
      .raddr (ram_ra),
      .rdata (ram_rd)
   );

   p_fill_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_busy_o && ram_we) |-> (ram_wd == FILL_BYTE || ram_wd == SEED_BYTE));
   p_seed_cell_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_busy_o && ram_we && ram_wa == AW'(SEED_COL)) |-> ram_wd == SEED_BYTE);
endmodule

// File: tb/ttx_i2c_regif_tb.sv
module ttx_i2c_regif_tb;
   localparam int         Q   = 5;
   localparam logic [6:0] DEV = 7'h11;
   // fields {chapter[20:19], row[18:14], col[13:8], data[7:0]}
   localparam logic [20:0] VEC [6] = '{
      {2'd0, 5'd0,  6'd0,  8'hA5},
      {2'd1, 5'd12, 6'd20, 8'h3C},
      {2'd2, 5'd24, 6'd39, 8'hFF},
      {2'd3, 5'd0,  6'd0,  8'h00},
      {2'd3, 5'd24, 6'd39, 8'h5A},
      {2'd0, 5'd0,  6'd7,  8'h81}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        m_low = 1'b0;
   logic        good = 1'b0, r60 = 1'b0;
   logic        sda_oe, busy;
   logic [87:0] ctrl;
   wire         sda_line = ~(m_low | sda_oe);

   int checks = 0, errs = 0;
   bit done = 0;
   logic [7:0] wbuf [8];
   logic [7:0] rbuf [4];

   always #5 clk = ~clk;

   ttx_i2c_regif u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .sync_good_i(good), .rate60_i(r60), .ctrl_o(ctrl), .clr_busy_o(busy)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] creg(input int n);
      return ctrl[8*n +: 8];
   endfunction

   task automatic bus_start();
      m_low = 0; tick(Q); scl = 1; tick(Q); m_low = 1; tick(Q); scl = 0; tick(Q);
   endtask

   task automatic bus_stop();
      m_low = 1; tick(Q); scl = 1; tick(Q); m_low = 0; tick(Q);
   endtask

   task automatic send(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_low = ~d[i]; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
      end
      m_low = 0; tick(Q); scl = 1; tick(Q); ack = (sda_line == 1'b0); tick(Q); scl = 0; tick(Q);
   endtask

   task automatic recv(output logic [7:0] d, input logic give_ack);
      for (int i = 7; i >= 0; i--) begin
         m_low = 0; tick(Q); scl = 1; tick(Q); d[i] = sda_line; tick(Q); scl = 0; tick(Q);
      end
      m_low = give_ack; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); m_low = 0;
   endtask

   task automatic i2c_write(input logic [6:0] dev, input logic [7:0] sub, input int n, output logic ok);
      logic a;
      bus_start();
      send({dev, 1'b0}, a); ok = a;
      if (a) begin
         send(sub, a); ok &= a;
         for (int i = 0; i < n; i++) begin send(wbuf[i], a); ok &= a; end
      end
      bus_stop();
   endtask

   task automatic i2c_read(input logic [7:0] sub, input int n, output logic ok);
      logic a;
      bus_start();
      send({DEV, 1'b0}, a); ok = a;
      send(sub, a); ok &= a;
      bus_start();
      send({DEV, 1'b1}, a); ok &= a;
      for (int i = 0; i < n; i++) recv(rbuf[i], i < n - 1);
      bus_stop();
   endtask

   task automatic mem_write(input logic [1:0] c, input logic [4:0] r, input logic [5:0] k, input logic [7:0] d);
      logic ok;
      wbuf[0] = {6'd0, c}; wbuf[1] = {3'd0, r}; wbuf[2] = {2'd0, k}; wbuf[3] = d;
      i2c_write(DEV, 8'h08, 4, ok);
      chk("R1 ack on window write", ok, 1);
   endtask

   task automatic mem_read(input logic [1:0] c, input logic [4:0] r, input logic [5:0] k, output logic [7:0] d);
      logic ok;
      wbuf[0] = {6'd0, c}; wbuf[1] = {3'd0, r}; wbuf[2] = {2'd0, k};
      i2c_write(DEV, 8'h08, 3, ok);
      i2c_read(8'h0B, 1, ok);
      d = rbuf[0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic ok;
      tick(3); rst_n = 1; tick(1);
      // R3 reset register values, R7 sweep active, R10 bus released
      for (int i = 0; i < 11; i++)
         chk($sformatf("R3 reset reg %0d", i), creg(i), (i == 5 || i == 6) ? 8'h03 : 8'h00);
      chk("R7 busy after reset", busy, 1);
      chk("R10 sda released at reset", sda_oe, 0);
      while (busy) tick(1);
      chk("R7 busy cleared", busy, 0);
      mem_read(0, 0, 7, d); chk("R7 seed cell", d, 8'h07);
      mem_read(0, 0, 6, d); chk("R7 fill cell", d, 8'h20);
      mem_read(3, 24, 39, d); chk("R7 last cell", d, 8'h20);

      // R2 burst with auto-increment
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      i2c_write(DEV, 8'h02, 3, ok);
      chk("R1 ack matching address", ok, 1);
      chk("R2 reg 02", creg(2), 8'h11);
      chk("R2 reg 03", creg(3), 8'h22);
      chk("R2 reg 04", creg(4), 8'h33);
      chk("R3 reg 05 untouched", creg(5), 8'h03);

      // R1 foreign address
      wbuf[0] = 8'h02;
      i2c_write(7'h12, 8'h04, 1, ok);
      chk("R1 no ack foreign", ok, 0);
      chk("R1 reg 04 unchanged", creg(4), 8'h33);

      // R5 table walk: write all, then read all back
      for (int i = 0; i < 6; i++)
         mem_write(VEC[i][20:19], VEC[i][18:14], VEC[i][13:8], VEC[i][7:0]);
      for (int i = 0; i < 6; i++) begin
         mem_read(VEC[i][20:19], VEC[i][18:14], VEC[i][13:8], d);
         chk($sformatf("R5 vector %0d", i), d, VEC[i][7:0]);
      end

      // R4 write-only reads, R10 multi-byte read crossing into window
      i2c_read(8'h05, 1, ok);
      chk("R4 read reg 05", rbuf[0], 8'h00);
      i2c_read(8'h0A, 2, ok);
      chk("R4 read reg 0A", rbuf[0], 8'h00);
      chk("R10 second byte from window", rbuf[1], 8'h81);
      chk("R10 released after nack", sda_oe, 0);

      // R2 wrap 0Bh -> 00h
      mem_write(0, 1, 1, 8'h6E);
      wbuf[0] = 8'h6F; wbuf[1] = 8'h01;
      i2c_write(DEV, 8'h0B, 2, ok);
      chk("R2 wrap into reg 00", creg(0), 8'h01);

      // R6 status byte
      good = 1; r60 = 1; tick(2);
      i2c_read(8'h0B, 1, ok); chk("R6 good 60Hz", rbuf[0], 8'h81);
      good = 0; r60 = 1; tick(2);
      i2c_read(8'h0B, 1, ok); chk("R6 bad sync masks rate", rbuf[0], 8'h00);
      good = 1; r60 = 0; tick(2);
      i2c_read(8'h0B, 1, ok); chk("R6 good 50Hz", rbuf[0], 8'h01);

      // R5 window write with status selected still hits memory
      mem_write(0, 2, 2, 8'h5D);
      wbuf[0] = 8'h00;
      i2c_write(DEV, 8'h00, 1, ok);
      chk("R3 reg 00 cleared", creg(0), 8'h00);
      mem_read(0, 1, 1, d); chk("R2 wrap byte stored", d, 8'h6F);
      mem_read(0, 2, 2, d); chk("R5 write while status selected", d, 8'h5D);

      // R9 out-of-range window
      mem_write(0, 25, 0, 8'h44);
      mem_read(0, 25, 0, d); chk("R9 row out of range reads 00", d, 8'h00);
      mem_read(1, 0, 0, d); chk("R9 no alias for bad row", d, 8'h20);
      mem_write(2, 3, 40, 8'h44);
      mem_read(2, 4, 0, d); chk("R9 no alias for bad column", d, 8'h20);

      // R8 clear with a window write during the sweep
      wbuf[0] = 8'h09; wbuf[1] = 8'h05; wbuf[2] = 8'h05; wbuf[3] = 8'h99;
      i2c_write(DEV, 8'h08, 4, ok);
      chk("R8 busy during clear", busy, 1);
      chk("R8 clear bit not kept", creg(8), 8'h01);
      while (busy) tick(1);
      mem_read(1, 5, 5, d); chk("R8 write during sweep dropped", d, 8'h20);
      mem_read(2, 24, 39, d); chk("R8 cell refilled", d, 8'h20);
      mem_read(0, 0, 7, d); chk("R8 seed restored", d, 8'h07);
      mem_read(0, 1, 1, d); chk("R8 written cell refilled", d, 8'h20);
      chk("R10 released at end", sda_oe, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule